// File: doc/BRIEF.md
# GPIO Line Interrupt Controller

This block turns the input levels of three 8-line GPIO ports into interrupt requests. The ports are numbered 0, 1 and 2. Each line can fire on a level or on an edge, with a selectable polarity. It has its own enable bit and an optional debounce filter, clocked by an external sample strobe. An edge is captured in a per-line latch. The latch holds until software writes a one to that line's bit in the port's end-of-interrupt register. A level-triggered line reports its pin's state directly and keeps no memory.

Every pin goes through a two-flop synchronizer before the trigger logic. Ports 0 and 1 share a single interrupt output. Software finds which line is pending by reading the status register of each of those two ports. Each of the eight lines of port 2 has its own interrupt output. All configuration is held in byte-wide registers that are banked per port and reached through a simple write-strobe register bus. Reads are combinational on the address.

Top module: `gpio_irq_unit`

## Requirements
- R1: After reset every register reads 0, `irq_ab` is 0 and `irq_f` is 0.
- R2: Registers sit at these byte addresses, listed as port 0 / port 1 / port 2:
  - trigger-kind: 0x90 / 0xAC / 0x4C
  - polarity: 0x94 / 0xB0 / 0x50
  - end-of-interrupt: 0x98 / 0xB4 / 0x54
  - enable: 0x9C / 0xB8 / 0x58
  - debounce: 0xA8 / 0xC4 / 0x64

  Bit i of a register belongs to line i. Writes are read back unchanged. End-of-interrupt and unmapped addresses read 0.
- R3: A line whose trigger-kind bit is 0 is level-triggered. It is pending while its filtered input equals its polarity bit (1 = high, 0 = low). It stops being pending as soon as the input no longer matches, and it latches nothing.
- R4: A line whose trigger-kind bit is 1 is edge-triggered. With polarity 1 a 0-to-1 change of the filtered input sets its latch; with polarity 0 a 1-to-0 change sets it. The opposite edge sets nothing. The latch stays set after the input returns.
- R5: Writing the end-of-interrupt register clears the latch of every line whose written bit is 1. Lines written with 0 keep their latch.
- R6: A line is pending only while its enable bit is 1. An edge that occurs while the line is disabled is not latched. Clearing the enable bit hides a set latch but does not clear it, so re-enabling the line shows the latch again.
- R7: `irq_ab` is 1 when any line of port 0 or port 1 is pending. The status registers of port 0 (0xA0) and port 1 (0xBC) read the pending lines, bit i = line i.
- R8: `irq_f[i]` is 1 exactly when line i of port 2 is pending.
- R9: With a line's debounce bit set, its filtered input takes a new value only after 4 consecutive `db_tick` samples of that value. A shorter excursion is ignored, and nothing changes between ticks.
- R10: With debounce off, a pin change made between clock edges shows on a level-triggered pending output after the third rising edge, and not after the second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 8 | Byte address for writes and reads |
| reg_wdata | input | 8 | Write data, bit i = line i |
| reg_rdata | output | 8 | Read data for `reg_addr` (combinational) |
| db_tick | input | 1 | Debounce sample strobe |
| pin_a | input | 8 | Port 0 pin levels |
| pin_b | input | 8 | Port 1 pin levels |
| pin_f | input | 8 | Port 2 pin levels |
| irq_ab | output | 1 | Shared interrupt for ports 0 and 1 |
| irq_f | output | 8 | Per-line interrupt for port 2 |

## Verification
Directed sequences pin down the three-edge input latency, a rising versus a falling trigger on the same line, an edge seen while disabled versus while enabled, and an end-of-interrupt mask with zero bits versus a matching bit. A debounce sequence separates an excursion of two ticks from one of four ticks. Random phases rewrite the trigger-kind, polarity and enable registers of random ports and toggle all 24 pins at once. Because every line carries a different mix of edge and level modes, each step tells a latched edge from a live level and a matching edge from an opposite one. The expected status words are computed by bench functions from the requirements.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;

    localparam int NUM_PORTS = 3;
    localparam int ADDR_W    = 8;

    typedef enum logic [2:0] {
        REG_KIND  = 3'd0,
        REG_POL   = 3'd1,
        REG_EOI   = 3'd2,
        REG_EN    = 3'd3,
        REG_STAT  = 3'd4,
        REG_DB    = 3'd5
    } reg_kind_e;

    localparam int NUM_KINDS = 6;

    function automatic logic [ADDR_W-1:0] port_base(input int port);
        case (port)
            0:       return 8'h90;
            1:       return 8'hAC;
            default: return 8'h4C;
        endcase
    endfunction

    function automatic logic [ADDR_W-1:0] reg_offset(input int port, input reg_kind_e kind);
        logic [ADDR_W-1:0] rel;
        case (kind)
            REG_KIND: rel = 8'h00;
            REG_POL:  rel = 8'h04;
            REG_EOI:  rel = 8'h08;
            REG_EN:   rel = 8'h0C;
            REG_STAT: rel = 8'h10;
            default:  rel = 8'h18;
        endcase
        return port_base(port) + rel;
    endfunction

endpackage

// File: rtl/gpio_in_cond.sv
module gpio_in_cond #(
    parameter int LINES       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DB_SAMPLES  = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [LINES-1:0] pin_i,
    input  logic [LINES-1:0] db_en_i,
    input  logic             db_tick_i,
    output logic [LINES-1:0] filt_o
);

    localparam int LAST = SYNC_STAGES - 1;

    typedef struct packed {
        logic [SYNC_STAGES-1:0][LINES-1:0] sync;
        logic [LINES-1:0][DB_SAMPLES-1:0]  hist;
        logic [LINES-1:0]                  filt;
    } cond_t;

    cond_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        s_d.sync[0] = pin_i;
        for (int k = 1; k < SYNC_STAGES; k++) begin
            s_d.sync[k] = s_q.sync[k-1];
        end
        for (int i = 0; i < LINES; i++) begin
            if (db_tick_i) begin
                s_d.hist[i] = {s_q.hist[i][DB_SAMPLES-2:0], s_q.sync[LAST][i]};
            end
            if (!db_en_i[i]) begin
                s_d.filt[i] = s_q.sync[LAST][i];
            end else if (db_tick_i && (&s_d.hist[i])) begin
                s_d.filt[i] = 1'b1;
            end else if (db_tick_i && !(|s_d.hist[i])) begin
                s_d.filt[i] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign filt_o = s_q.filt;

endmodule

// File: rtl/gpio_port_irq.sv
module gpio_port_irq
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we_i,
    input  reg_kind_e        kind_i,
    input  logic [LINES-1:0] wdata_i,
    input  logic [LINES-1:0] filt_i,
    output logic [LINES-1:0] kind_o,
    output logic [LINES-1:0] pol_o,
    output logic [LINES-1:0] en_o,
    output logic [LINES-1:0] db_o,
    output logic [LINES-1:0] latch_o,
    output logic [LINES-1:0] stat_o
);

    typedef struct packed {
        logic [LINES-1:0] kind;
        logic [LINES-1:0] pol;
        logic [LINES-1:0] en;
        logic [LINES-1:0] db;
        logic [LINES-1:0] latch;
        logic [LINES-1:0] prev;
    } port_t;

    port_t s_d, s_q;
    logic [LINES-1:0] rise_w, fall_w, hit_w, clr_w;

    always_comb begin
        s_d    = s_q;
        rise_w = filt_i & ~s_q.prev;
        fall_w = ~filt_i & s_q.prev;
        hit_w  = s_q.en & s_q.kind & ((s_q.pol & rise_w) | (~s_q.pol & fall_w));
        clr_w  = (we_i && kind_i == REG_EOI) ? wdata_i : '0;
        s_d.prev  = filt_i;
        s_d.latch = (s_q.latch & ~clr_w) | hit_w;
        if (we_i) begin
            case (kind_i)
                REG_KIND: s_d.kind = wdata_i;
                REG_POL:  s_d.pol  = wdata_i;
                REG_EN:   s_d.en   = wdata_i;
                REG_DB:   s_d.db   = wdata_i;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign kind_o  = s_q.kind;
    assign pol_o   = s_q.pol;
    assign en_o    = s_q.en;
    assign db_o    = s_q.db;
    assign latch_o = s_q.latch;
    assign stat_o  = s_q.en & ((s_q.kind & s_q.latch) | (~s_q.kind & ~(filt_i ^ s_q.pol)));

endmodule

// File: rtl/gpio_irq_unit.sv
module gpio_irq_unit
    import gpio_irq_pkg::*;
#(
    parameter int LINES       = 8,
    parameter int SYNC_STAGES = 2,
    parameter int DB_SAMPLES  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [LINES-1:0]  reg_wdata,
    output logic [LINES-1:0]  reg_rdata,
    input  logic              db_tick,
    input  logic [LINES-1:0]  pin_a,
    input  logic [LINES-1:0]  pin_b,
    input  logic [LINES-1:0]  pin_f,
    output logic              irq_ab,
    output logic [LINES-1:0]  irq_f
);

    localparam int STAT_PORTS = 2;
    localparam int DED_PORT   = NUM_PORTS - 1;

    logic [NUM_PORTS-1:0][LINES-1:0] pins_w, filt_w, kind_w, pol_w, en_w, db_w, latch_w, stat_w;
    logic [NUM_PORTS-1:0]            we_w;
    reg_kind_e                       sel_w [NUM_PORTS];

    assign pins_w[0] = pin_a;
    assign pins_w[1] = pin_b;
    assign pins_w[2] = pin_f;

    always_comb begin
        reg_rdata = '0;
        for (int p = 0; p < NUM_PORTS; p++) begin
            we_w[p]  = 1'b0;
            sel_w[p] = REG_KIND;
            for (int k = 0; k < NUM_KINDS; k++) begin
                if (reg_addr == reg_offset(p, reg_kind_e'(k))) begin
                    sel_w[p] = reg_kind_e'(k);
                    we_w[p]  = reg_wr && (reg_kind_e'(k) != REG_STAT);
                    case (reg_kind_e'(k))
                        REG_KIND: reg_rdata = kind_w[p];
                        REG_POL:  reg_rdata = pol_w[p];
                        REG_EN:   reg_rdata = en_w[p];
                        REG_DB:   reg_rdata = db_w[p];
                        REG_STAT: reg_rdata = (p < STAT_PORTS) ? stat_w[p] : '0;
                        default:  reg_rdata = '0;
                    endcase
                end
            end
        end
    end

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_port
        gpio_in_cond #(
            .LINES      (LINES),
            .SYNC_STAGES(SYNC_STAGES),
            .DB_SAMPLES (DB_SAMPLES)
        ) u_cond (
            .clk      (clk),
            .rst_n    (rst_n),
            .pin_i    (pins_w[p]),
            .db_en_i  (db_w[p]),
            .db_tick_i(db_tick),
            .filt_o   (filt_w[p])
        );

        gpio_port_irq #(
            .LINES(LINES)
        ) u_irq (
            .clk    (clk),
            .rst_n  (rst_n),
            .we_i   (we_w[p]),
            .kind_i (sel_w[p]),
            .wdata_i(reg_wdata),
            .filt_i (filt_w[p]),
            .kind_o (kind_w[p]),
            .pol_o  (pol_w[p]),
            .en_o   (en_w[p]),
            .db_o   (db_w[p]),
            .latch_o(latch_w[p]),
            .stat_o (stat_w[p])
        );
    end

    assign irq_ab = (|stat_w[0]) | (|stat_w[1]);
    assign irq_f  = stat_w[DED_PORT];

endmodule

// File: rtl/gpio_irq_unit_chk.sv
module gpio_irq_unit_chk
    import gpio_irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input logic                            clk,
    input logic                            rst_n,
    input logic                            reg_wr,
    input logic [ADDR_W-1:0]               reg_addr,
    input logic [LINES-1:0]                reg_wdata,
    input logic                            irq_ab,
    input logic [LINES-1:0]                irq_f,
    input logic [NUM_PORTS-1:0][LINES-1:0] en,
    input logic [NUM_PORTS-1:0][LINES-1:0] kind,
    input logic [NUM_PORTS-1:0][LINES-1:0] latch,
    input logic [NUM_PORTS-1:0][LINES-1:0] stat
);

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!irq_ab && irq_f == '0));

    assert_ab_output_R7: assert property (@(posedge clk) disable iff (!rst_n)
        irq_ab == ((|stat[0]) || (|stat[1])));

    assert_f_output_R8: assert property (@(posedge clk) disable iff (!rst_n)
        irq_f == stat[NUM_PORTS-1]);

    for (genvar p = 0; p < NUM_PORTS; p++) begin : g_chk
        assert_level_no_latch_R3: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> ((latch[p] & ~$past(latch[p]) & ~$past(kind[p])) == '0));

        assert_eoi_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
            (reg_wr && reg_addr == reg_offset(p, REG_EOI) && en[p] == '0)
            |=> ((latch[p] & $past(reg_wdata)) == '0));

        assert_disabled_no_latch_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (en[p] == '0) |=> ((latch[p] & ~$past(latch[p])) == '0));

        assert_status_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
            (stat[p] & ~en[p]) == '0);
    end

endmodule

bind gpio_irq_unit gpio_irq_unit_chk #(.LINES(LINES)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .reg_wr   (reg_wr),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .irq_ab   (irq_ab),
    .irq_f    (irq_f),
    .en       (en_w),
    .kind     (kind_w),
    .latch    (latch_w),
    .stat     (stat_w)
);

// File: tb/gpio_irq_unit_test.sv
module gpio_irq_unit_test;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       reg_wr = 1'b0;
    logic [7:0] reg_addr = '0;
    logic [7:0] reg_wdata = '0;
    logic [7:0] reg_rdata;
    logic       db_tick = 1'b0;
    logic [7:0] pin_v [3];
    logic       irq_ab;
    logic [7:0] irq_f;

    int checks = 0;
    int fails = 0;
    bit done = 1'b0;

    logic [7:0] m_kind [3];
    logic [7:0] m_pol [3];
    logic [7:0] m_en [3];
    logic [7:0] m_latch [3];

    always #4 clk = ~clk;

    gpio_irq_unit uut (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .db_tick(db_tick),
        .pin_a(pin_v[0]), .pin_b(pin_v[1]), .pin_f(pin_v[2]),
        .irq_ab(irq_ab), .irq_f(irq_f)
    );

    // kind: 0 trigger-kind, 1 polarity, 2 end-of-interrupt, 3 enable, 4 status, 5 debounce
    function automatic logic [7:0] addr_of(input int p, input int k);
        logic [7:0] base, rel;
        base = (p == 0) ? 8'h90 : (p == 1) ? 8'hAC : 8'h4C;
        case (k)
            0: rel = 8'h00;
            1: rel = 8'h04;
            2: rel = 8'h08;
            3: rel = 8'h0C;
            4: rel = 8'h10;
            default: rel = 8'h18;
        endcase
        return base + rel;
    endfunction

    function automatic logic [7:0] exp_stat(input logic [7:0] en, kd, pl, lt, pin);
        return en & ((kd & lt) | (~kd & ~(pin ^ pl)));
    endfunction

    function automatic logic [7:0] exp_hit(input logic [7:0] en, kd, pl, oldp, newp);
        return en & kd & ((pl & ~oldp & newp) | (~pl & oldp & ~newp));
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wait_n(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic tick();
        @(negedge clk);
        db_tick = 1'b1;
        @(negedge clk);
        db_tick = 1'b0;
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        for (int p = 0; p < 3; p++) begin
            pin_v[p] = '0; m_kind[p] = '0; m_pol[p] = '0; m_en[p] = '0; m_latch[p] = '0;
        end
        repeat (4) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic summary();
        $display("%0d/%0d checks passed", checks - fails, checks);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog: actual running expected finished");
            summary();
            $finish;
        end
    end

    initial begin
        logic [7:0] d;
        void'($urandom(32'h5EED_1234));
        do_reset();

        // R1 reset state
        check("R1 irq_ab", irq_ab, 0);
        check("R1 irq_f", irq_f, 0);
        rd(8'h90, d); check("R1 kind A", d, 0);
        rd(8'h58, d); check("R1 enable F", d, 0);
        rd(8'hA0, d); check("R1 status A", d, 0);

        // R2 readback at fixed addresses
        wr(8'h90, 8'h5A); rd(8'h90, d); check("R2 kind A 0x90", d, 8'h5A);
        wr(8'hB0, 8'hC3); rd(8'hB0, d); check("R2 pol B 0xB0", d, 8'hC3);
        wr(8'h64, 8'h0F); rd(8'h64, d); check("R2 debounce F 0x64", d, 8'h0F);
        wr(8'h58, 8'h81); rd(8'h58, d); check("R2 enable F 0x58", d, 8'h81);
        rd(8'h98, d); check("R2 eoi reads 0", d, 0);
        rd(8'h00, d); check("R2 unmapped reads 0", d, 0);
        // port F lines 0 and 7: level-low, pins low
        check("R8 level-low lines pending", irq_f, 8'h81);
        wr(8'h90, 0); wr(8'hB0, 0); wr(8'h64, 0); wr(8'h58, 0);
        check("R6 disabled hides level", irq_f, 0);

        // R10 latency, port B line 2 level-high
        wr(8'hB0, 8'h04); wr(8'hB8, 8'h04);
        pin_v[1] = 8'h04;
        wait_n(2); check("R10 not after 2nd edge", irq_ab, 0);
        wait_n(1); check("R10 after 3rd edge", irq_ab, 1);
        rd(8'hBC, d); check("R7 status B", d, 8'h04);
        rd(8'hA0, d); check("R7 status A idle", d, 0);
        pin_v[1] = 8'h00;
        wait_n(4); check("R3 level drops, no latch", irq_ab, 0);
        wr(8'hB0, 0); wr(8'hB8, 0);

        // R4/R5/R6 port F line 3, rising edge
        wr(8'h4C, 8'h08); wr(8'h50, 8'h08);
        pin_v[2] = 8'h08; wait_n(6);
        wr(8'h58, 8'h08); wait_n(1);
        check("R6 edge while disabled not latched", irq_f, 0);
        pin_v[2] = 8'h00; wait_n(6);
        check("R4 opposite edge ignored", irq_f, 0);
        pin_v[2] = 8'h08; wait_n(6);
        check("R4 rising edge latched", irq_f, 8'h08);
        pin_v[2] = 8'h00; wait_n(6);
        check("R4 latch holds after return", irq_f, 8'h08);
        wr(8'h58, 8'h00); check("R6 disable hides latch", irq_f, 0);
        wr(8'h58, 8'h08); check("R6 re-enable shows latch", irq_f, 8'h08);
        wr(8'h54, 8'hF7); check("R5 zero bit keeps latch", irq_f, 8'h08);
        wr(8'h54, 8'h08); check("R5 one bit clears latch", irq_f, 0);
        wr(8'h50, 8'h00);
        pin_v[2] = 8'h08; wait_n(6);
        check("R4 rising ignored in falling mode", irq_f, 0);
        pin_v[2] = 8'h00; wait_n(6);
        check("R4 falling edge latched", irq_f, 8'h08);
        wr(8'h54, 8'h08); wr(8'h4C, 0); wr(8'h58, 0);

        // R9 debounce, port A line 0 level-high
        wr(8'h94, 8'h01); wr(8'h9C, 8'h01); wr(8'hA8, 8'h01);
        pin_v[0] = 8'h01; wait_n(5);
        check("R9 no change without ticks", irq_ab, 0);
        tick(); tick(); tick();
        check("R9 three samples not enough", irq_ab, 0);
        tick();
        check("R9 fourth sample passes", irq_ab, 1);
        pin_v[0] = 8'h00; wait_n(4);
        tick(); tick();
        check("R9 short low excursion held", irq_ab, 1);
        pin_v[0] = 8'h01; wait_n(4);
        tick(); tick(); tick(); tick();
        check("R9 stays high", irq_ab, 1);
        pin_v[0] = 8'h00; wait_n(4);
        tick(); tick(); tick(); tick();
        check("R9 long low passes", irq_ab, 0);

        // Random phase: R3 R4 R5 R7 R8
        do_reset();
        for (int it = 0; it < 300; it++) begin
            int p, k;
            logic [7:0] v, np [3], ea, eb, ef;
            p = $urandom % 3;
            k = $urandom % 3;
            v = 8'($urandom);
            if (k == 0) begin wr(addr_of(p, 0), v); m_kind[p] = v; end
            else if (k == 1) begin wr(addr_of(p, 1), v); m_pol[p] = v; end
            else begin wr(addr_of(p, 3), v); m_en[p] = v; end
            wait_n(2);
            for (int q = 0; q < 3; q++) begin
                np[q] = 8'($urandom);
                m_latch[q] = m_latch[q] | exp_hit(m_en[q], m_kind[q], m_pol[q], pin_v[q], np[q]);
                pin_v[q] = np[q];
            end
            wait_n(8);
            ea = exp_stat(m_en[0], m_kind[0], m_pol[0], m_latch[0], pin_v[0]);
            eb = exp_stat(m_en[1], m_kind[1], m_pol[1], m_latch[1], pin_v[1]);
            ef = exp_stat(m_en[2], m_kind[2], m_pol[2], m_latch[2], pin_v[2]);
            rd(8'hA0, d); check("R3/R4 status A", d, ea);
            rd(8'hBC, d); check("R3/R4 status B", d, eb);
            check("R7 irq_ab", irq_ab, (ea != 0 || eb != 0));
            check("R8 irq_f", irq_f, ef);
            if ($urandom % 3 == 0) begin
                p = $urandom % 3;
                v = 8'($urandom);
                wr(addr_of(p, 2), v);
                m_latch[p] = m_latch[p] & ~v;
                ef = exp_stat(m_en[2], m_kind[2], m_pol[2], m_latch[2], pin_v[2]);
                ea = exp_stat(m_en[0], m_kind[0], m_pol[0], m_latch[0], pin_v[0]);
                eb = exp_stat(m_en[1], m_kind[1], m_pol[1], m_latch[1], pin_v[1]);
                check("R5 eoi irq_f", irq_f, ef);
                check("R5 eoi irq_ab", irq_ab, (ea != 0 || eb != 0));
            end
        end

        done = 1'b1;
        summary();
        $finish;
    end

endmodule